// File: doc/BRIEF.md
# Extended Block Fill Unit

The fill unit sits behind the decoder of a decoded-micro-op cache. It accepts one decoded micro-op per cycle, along with the instruction pointer of that micro-op and a set of control-flow class flags. It gathers these micro-ops into an extended block held in a fill buffer. It closes the block when it meets a control-flow instruction that must be predicted, or when the block reaches its size quota. A conditional branch that is marked strongly biased is promoted: the unit absorbs it and keeps building. An unconditional direct jump is absorbed in the same way.

The buffer is filled back-to-front. Each new micro-op enters slot 0 and pushes the older ones up by one slot. When the block closes, slot 0 therefore holds the last micro-op and slot `len-1` holds the first. A block can then grow at its front without its stored micro-ops moving.

The finished block is tagged with the instruction pointer of its closing micro-op. It is presented with its length and a close reason, and held until downstream takes it. While a block waits, the input side is stalled. Once the block is taken, the buffer is cleared, and the next micro-op starts a fresh block in the following cycle.

Top module: `xb_fill_unit`

## Requirements
- R1: After reset, `blk_valid_o` is 0, `in_ready_o` is 1 and every slot of `blk_uops_o` is zero.
- R2: An accepted micro-op with `in_cond_i`=1 and `in_biased_i`=0 closes the block, with `blk_reason_o`=1.
- R3: An accepted micro-op whose only class flags are `in_jmp_i`, or `in_cond_i` together with `in_biased_i`, does not close the block, unless R5 applies.
- R4: An accepted indirect branch, call or return closes the block, with reason 2, 3 or 4 respectively. When several class flags are set on one micro-op, the reason follows the priority return > call > indirect > unbiased conditional.
- R5: The micro-op that brings the block to QUOTA micro-ops closes it. The reason is 5 when no class flag of R2 or R4 applies to that micro-op.
- R6: `blk_len_o` equals the number of micro-ops accepted into the block, from 1 to QUOTA.
- R7: `blk_tag_o` equals the `in_ip_i` of the closing micro-op.
- R8: Slot k of `blk_uops_o` (bits `k*UOP_W +: UOP_W`) holds the micro-op accepted k positions before the closing one, with slot 0 holding the closing micro-op. Slots k >= len read zero.
- R9: While `blk_valid_o`=1, `in_ready_o` is 0. If `blk_ready_i`=0, the block outputs stay unchanged.
- R10: In the cycle after `blk_valid_o` and `blk_ready_i` are both 1, `blk_valid_o` is 0, `in_ready_o` is 1 and all slots read zero. The next micro-op starts a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Micro-op offered |
| in_ready_o | output | 1 | Unit can take a micro-op |
| in_uop_i | input | UOP_W | Decoded micro-op payload |
| in_ip_i | input | IP_W | Instruction pointer of the micro-op |
| in_cond_i | input | 1 | Conditional branch |
| in_biased_i | input | 1 | Conditional branch is strongly biased (promote) |
| in_ind_i | input | 1 | Indirect branch |
| in_call_i | input | 1 | Call |
| in_ret_i | input | 1 | Return |
| in_jmp_i | input | 1 | Unconditional direct jump |
| blk_valid_o | output | 1 | Finished block presented |
| blk_ready_i | input | 1 | Downstream takes the block |
| blk_len_o | output | $clog2(QUOTA+1) | Micro-op count of the block |
| blk_tag_o | output | IP_W | Instruction pointer of the closing micro-op |
| blk_reason_o | output | 3 | Close reason: 1 cond, 2 indirect, 3 call, 4 return, 5 quota |
| blk_uops_o | output | QUOTA*UOP_W | Reversed micro-op slots |

## Verification
The bench builds the unit with QUOTA=4, UOP_W=8 and IP_W=16. At that size it can sweep every block length from one micro-op up to the quota against every closing class, and the quota-forced close. The filler micro-ops rotate through plain, jump and biased-conditional classes, so absorption is seen at every position, including the quota slot. A small quota also makes every unused-slot and full-buffer case short to reach. Multi-flag priority, and a stall with downstream not ready, are exercised on top of the sweep.

// File: rtl/xb_fill_pkg.sv
package xb_fill_pkg;
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_COND  = 3'd1,
    RSN_IND   = 3'd2,
    RSN_CALL  = 3'd3,
    RSN_RET   = 3'd4,
    RSN_QUOTA = 3'd5
  } close_rsn_e;
endpackage

// File: rtl/xb_close_detect.sv
module xb_close_detect
  import xb_fill_pkg::*;
(
  input  logic       cond_i,
  input  logic       biased_i,
  input  logic       ind_i,
  input  logic       call_i,
  input  logic       ret_i,
  input  logic       jmp_i,
  input  logic       quota_hit_i,
  output close_rsn_e rsn_o
);
  always_comb begin
    if (ret_i)                  rsn_o = RSN_RET;
    else if (call_i)            rsn_o = RSN_CALL;
    else if (ind_i)             rsn_o = RSN_IND;
    else if (cond_i && !biased_i) rsn_o = RSN_COND;
    else if (quota_hit_i)       rsn_o = RSN_QUOTA;
    else                        rsn_o = RSN_NONE;
  end

  always_comb begin
    if (!quota_hit_i && !ind_i && !call_i && !ret_i && !cond_i && jmp_i)
      AST_JMP_ABSORB: assert (rsn_o == RSN_NONE) else $error("jump closed block"); // R3
    if (!quota_hit_i && !ind_i && !call_i && !ret_i && cond_i && biased_i)
      AST_BIASED_ABSORB: assert (rsn_o == RSN_NONE) else $error("biased cond closed block"); // R3
  end
endmodule

// File: rtl/xb_rev_buffer.sv
module xb_rev_buffer #(
  parameter int UOP_W = 16,
  parameter int DEPTH = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic                   clear_i,
  input  logic [UOP_W-1:0]       uop_i,
  output logic [DEPTH*UOP_W-1:0] slots_o
);
  logic [UOP_W-1:0] slot_q [DEPTH];

  // newest micro-op lands in slot 0, older ones move up
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [UOP_W-1:0] nxt;
    if (k == 0) begin : g_head
      assign nxt = uop_i;
    end else begin : g_body
      assign nxt = slot_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q[k] <= '0;
      else if (clear_i) slot_q[k] <= '0;
      else if (push_i)  slot_q[k] <= nxt;
    end
    assign slots_o[k*UOP_W +: UOP_W] = slot_q[k];
  end

  AST_HEAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clear_i |=> slot_q[0] == $past(uop_i)) else $error("head slot"); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> slot_q[DEPTH-1] == '0) else $error("clear"); // R10
endmodule

// File: rtl/xb_fill_ctrl.sv
module xb_fill_ctrl
  import xb_fill_pkg::*;
#(
  parameter int IP_W  = 32,
  parameter int QUOTA = 16,
  localparam int LEN_W = $clog2(QUOTA + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IP_W-1:0]  ip_i,
  input  close_rsn_e       rsn_i,
  input  logic             blk_ready_i,
  output logic             in_ready_o,
  output logic             push_o,
  output logic             clear_o,
  output logic             quota_hit_o,
  output logic             blk_valid_o,
  output logic [LEN_W-1:0] len_o,
  output logic [IP_W-1:0]  tag_o,
  output close_rsn_e       rsn_o
);
  logic [LEN_W-1:0] count_q;
  logic             done_q;
  logic [IP_W-1:0]  tag_q;
  close_rsn_e       rsn_q;
  logic             close;

  assign in_ready_o  = !done_q;
  assign push_o      = in_valid_i && in_ready_o;
  assign clear_o     = done_q && blk_ready_i;
  assign quota_hit_o = (count_q == LEN_W'(QUOTA - 1));
  assign close       = push_o && (rsn_i != RSN_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      done_q  <= 1'b0;
      tag_q   <= '0;
      rsn_q   <= RSN_NONE;
    end else if (clear_o) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (push_o) begin
      count_q <= count_q + 1'b1;
      if (close) begin
        done_q <= 1'b1;
        tag_q  <= ip_i;
        rsn_q  <= rsn_i;
      end
    end
  end

  assign blk_valid_o = done_q;
  assign len_o       = count_q;
  assign tag_o       = tag_q;
  assign rsn_o       = rsn_q;

  AST_HOLD_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && !blk_ready_i |=> blk_valid_o && $stable(len_o) && $stable(tag_o) && $stable(rsn_o))
    else $error("pending block changed"); // R9
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> (len_o != '0) && (len_o <= LEN_W'(QUOTA))) else $error("len range"); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= LEN_W'(QUOTA)) else $error("count overflow"); // R5
  AST_QUOTA_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && count_q == LEN_W'(QUOTA - 1) |=> blk_valid_o) else $error("quota"); // R5
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !blk_valid_o && len_o == '0 && in_ready_o) else $error("accept"); // R10
endmodule

// File: rtl/xb_fill_unit.sv
module xb_fill_unit
  import xb_fill_pkg::*;
#(
  parameter int UOP_W = 16,
  parameter int IP_W  = 32,
  parameter int QUOTA = 16,
  localparam int LEN_W = $clog2(QUOTA + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [UOP_W-1:0]       in_uop_i,
  input  logic [IP_W-1:0]        in_ip_i,
  input  logic                   in_cond_i,
  input  logic                   in_biased_i,
  input  logic                   in_ind_i,
  input  logic                   in_call_i,
  input  logic                   in_ret_i,
  input  logic                   in_jmp_i,
  output logic                   blk_valid_o,
  input  logic                   blk_ready_i,
  output logic [LEN_W-1:0]       blk_len_o,
  output logic [IP_W-1:0]        blk_tag_o,
  output logic [2:0]             blk_reason_o,
  output logic [QUOTA*UOP_W-1:0] blk_uops_o
);
  close_rsn_e rsn_in, rsn_out;
  logic       quota_hit, push, clear;

  xb_close_detect u_detect (
    .cond_i      (in_cond_i),
    .biased_i    (in_biased_i),
    .ind_i       (in_ind_i),
    .call_i      (in_call_i),
    .ret_i       (in_ret_i),
    .jmp_i       (in_jmp_i),
    .quota_hit_i (quota_hit),
    .rsn_o       (rsn_in)
  );

  xb_fill_ctrl #(.IP_W(IP_W), .QUOTA(QUOTA)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .ip_i        (in_ip_i),
    .rsn_i       (rsn_in),
    .blk_ready_i (blk_ready_i),
    .in_ready_o  (in_ready_o),
    .push_o      (push),
    .clear_o     (clear),
    .quota_hit_o (quota_hit),
    .blk_valid_o (blk_valid_o),
    .len_o       (blk_len_o),
    .tag_o       (blk_tag_o),
    .rsn_o       (rsn_out)
  );

  xb_rev_buffer #(.UOP_W(UOP_W), .DEPTH(QUOTA)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .clear_i (clear),
    .uop_i   (in_uop_i),
    .slots_o (blk_uops_o)
  );

  assign blk_reason_o = rsn_out;
endmodule

// File: tb/xb_fill_unit_bench.sv
module xb_fill_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int UOP_W = 8;
  localparam int IP_W  = 16;
  localparam int QUOTA = 4;
  localparam int LEN_W = $clog2(QUOTA + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, blk_ready = 1'b0;
  logic [UOP_W-1:0] in_uop = '0;
  logic [IP_W-1:0]  in_ip = '0;
  logic f_cond = 0, f_biased = 0, f_ind = 0, f_call = 0, f_ret = 0, f_jmp = 0;
  logic in_ready, blk_valid;
  logic [LEN_W-1:0] blk_len;
  logic [IP_W-1:0] blk_tag;
  logic [2:0] blk_reason;
  logic [QUOTA*UOP_W-1:0] blk_uops;

  int checks = 0, fails = 0;
  logic [UOP_W-1:0] model [QUOTA];
  int mlen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xb_fill_unit #(.UOP_W(UOP_W), .IP_W(IP_W), .QUOTA(QUOTA)) u_xb_fill_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_uop_i(in_uop), .in_ip_i(in_ip), .in_cond_i(f_cond), .in_biased_i(f_biased),
    .in_ind_i(f_ind), .in_call_i(f_call), .in_ret_i(f_ret), .in_jmp_i(f_jmp),
    .blk_valid_o(blk_valid), .blk_ready_i(blk_ready), .blk_len_o(blk_len),
    .blk_tag_o(blk_tag), .blk_reason_o(blk_reason), .blk_uops_o(blk_uops)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // flags: {jmp,biased,ret,call,ind,cond}
  task automatic send(input logic [UOP_W-1:0] u, input logic [IP_W-1:0] ip, input logic [5:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_uop = u; in_ip = ip;
    {f_jmp, f_biased, f_ret, f_call, f_ind, f_cond} = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; {f_jmp, f_biased, f_ret, f_call, f_ind, f_cond} = '0;
    model[mlen] = u; mlen++;
  endtask

  task automatic check_slots(input string req);
    for (int k = 0; k < QUOTA; k++)
      chk(req, $sformatf("slot%0d", k), int'(blk_uops[k*UOP_W +: UOP_W]),
          (k < mlen) ? int'(model[mlen-1-k]) : 0);
  endtask

  task automatic take_block(input int exp_rsn, input logic [IP_W-1:0] exp_tag, input bit stall, input string rreq);
    chk("R6", "blk_valid", int'(blk_valid), 1);
    chk("R6", "len", int'(blk_len), mlen);
    chk("R7", "tag", int'(blk_tag), int'(exp_tag));
    chk(rreq, "reason", int'(blk_reason), exp_rsn);
    check_slots("R8");
    if (stall) begin
      @(negedge clk);
      chk("R9", "in_ready stalled", int'(in_ready), 0);
      chk("R9", "valid held", int'(blk_valid), 1);
      chk("R9", "len held", int'(blk_len), mlen);
      chk("R9", "tag held", int'(blk_tag), int'(exp_tag));
    end
    blk_ready = 1'b1;
    @(negedge clk);
    blk_ready = 1'b0;
    mlen = 0;
    chk("R10", "valid after take", int'(blk_valid), 0);
    chk("R10", "in_ready after take", int'(in_ready), 1);
    check_slots("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid", int'(blk_valid), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "uops", (blk_uops == '0) ? 1 : 0, 1);

    // sweep length x closing class; kind 4 = quota
    for (int kind = 0; kind < 5; kind++) begin
      for (int len = 1; len <= QUOTA; len++) begin
        logic [IP_W-1:0] ip;
        logic [5:0] fl;
        int exp_rsn;
        string rreq;
        if (kind == 4 && len != QUOTA) continue;
        for (int i = 0; i < len - 1; i++) begin
          fl = (i % 3 == 1) ? 6'b100000 : (i % 3 == 2) ? 6'b010001 : 6'b000000;
          send(UOP_W'(kind*40 + len*8 + i + 1), IP_W'(16'h1000 + kind*256 + len*16 + i*2), fl);
          if (i < len - 1) chk("R3", "no close on filler", int'(blk_valid), 0);
        end
        case (kind)
          0: begin fl = 6'b000001; exp_rsn = 1; rreq = "R2"; end
          1: begin fl = 6'b000010; exp_rsn = 2; rreq = "R4"; end
          2: begin fl = 6'b000100; exp_rsn = 3; rreq = "R4"; end
          3: begin fl = 6'b001000; exp_rsn = 4; rreq = "R4"; end
          default: begin fl = 6'b010001; exp_rsn = 5; rreq = "R5"; end
        endcase
        ip = IP_W'(16'h1000 + kind*256 + len*16 + 14);
        send(UOP_W'(kind*40 + len*8 + 7), ip, fl);
        take_block(exp_rsn, ip, (len % 2) == 1, rreq);
      end
    end

    // jump-only micro-op at the quota slot still closes on quota
    for (int i = 0; i < QUOTA; i++) send(UOP_W'(200 + i), IP_W'(16'h3000 + i), 6'b100000);
    take_block(5, IP_W'(16'h3000 + QUOTA - 1), 1'b0, "R5");

    // priority among coexisting flags
    send(8'hA1, 16'h4000, 6'b001111);
    take_block(4, 16'h4000, 1'b0, "R4");
    send(8'hA2, 16'h4010, 6'b000111);
    take_block(3, 16'h4010, 1'b0, "R4");
    send(8'hA3, 16'h4020, 6'b000011);
    take_block(2, 16'h4020, 1'b1, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule